// File: doc/BRIEF.md
# Selectable-Order Sigma-Delta Tuning DAC

This block converts a wide digital tuning word into a one-bit pulse stream. The stream is meant to drive an external analog switch that steers a fixed current into the summing node of an inverting amplifier. An analog low-pass filter after that amplifier produces the oscillator tuning voltage. The tuning path is slow, so the block trades settling time for resolution. It advances only on a tick input, which can run far below the system clock.

A single core offers three ways to spread the word over time:
- a first-order noise-shaping loop, which is the baseline;
- a second-order noise-shaping loop;
- a plain PWM fallback on the same pin.

No loop above second order is provided. A higher-order single-bit loop would need stabilisation logic that this slow path does not justify.

The word, its number format and the mode are written together through a simple write strobe. They take effect only at the start of the next modulator frame, so a change never cuts a pulse pattern in mid-stream.

Top module: `sdd_ctrl_dac`

## Requirements
- R1: During reset `dac_out` is 0. After reset the block runs in first-order mode with the offset word at mid-scale (2^(WORD_W-1)), so the first 2^WORD_W ticks carry exactly 2^(WORD_W-1) ones.
- R2: With mode code 00, any 2^WORD_W consecutive ticks after the word takes effect carry exactly as many ones as the offset word's value.
- R3: A write (`wr_en`=1) stores word, format and mode as pending. The pending set becomes active only when the frame counter of 2^PWM_BITS ticks wraps. When several writes fall in one frame, the last one wins.
- R4: With `wr_signed`=1 the word is read as two's complement and mapped to offset form by adding 2^(WORD_W-1): the most negative code gives density 0 and code 0 gives one half. With `wr_signed`=0 the word is taken unsigned.
- R5: With mode code 01 and an offset word in the middle half of the range [2^WORD_W/4, 3*2^WORD_W/4], the ones over any 16*2^WORD_W consecutive ticks differ from 16 times the word by no more than 16. This is one LSB of density.
- R6: With mode code 10 the output is PWM. The period is 2^PWM_BITS ticks, and the output is high for a number of ticks equal to the top PWM_BITS bits of the offset word. A duty of 0 keeps the output low.
- R7: While `tick_en` is 0, no state advances and `dac_out` holds its value. Pulse widths and periods are counted in ticks, not in clocks.
- R8: The two error states of the second-order loop reset to zero and saturate at +/-2^(WORD_W+1) rather than wrapping. Because of this, even the extreme code 0 stays within one LSB of density in second-order mode.
- R9: Mode code 11 behaves the same as code 00 (first order).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Modulator advance strobe, one tick per asserted clock |
| wr_en | input | 1 | Stores word, format and mode as pending |
| wr_data | input | WORD_W | Tuning word |
| wr_signed | input | 1 | 1: word is two's complement; 0: word is unsigned |
| wr_mode | input | 2 | 00/11 first order, 01 second order, 10 PWM |
| dac_out | output | 1 | One-bit stream to the current-steering switch |

## Verification
An accumulator or error state that has gone wrong shows up as a count of ones that is off. In first-order mode it is off within a single window of 2^WORD_W ticks, because that window must hold exactly the word's value. A frame counter or load path that has gone wrong shows up as a PWM duty that is wrong within one period, or as a new word that shows up in the wrong place. Second-order faults show as a density outside the one-LSB band over a window of sixteen full-scale periods. A tick gate that has gone wrong shows up at once, as the output moving while `tick_en` is low.

// File: rtl/sdd_pkg.sv
// Shared definitions for the sigma-delta tuning DAC.
// Assumes: the mode field is two bits wide and is decoded only by the top level.
package sdd_pkg;

    // Modulator selection; the spare code falls back to first order.
    typedef enum logic [1:0] {
        SDD_ORD1  = 2'b00,
        SDD_ORD2  = 2'b01,
        SDD_PWM   = 2'b10,
        SDD_ORD1B = 2'b11
    } sdd_mode_e;

endpackage

// File: rtl/sdd_word_stage.sv
// Holds the pending tuning set written by the host and the active set used by
// the modulators. It also runs the frame counter and promotes the pending set
// only when the frame counter wraps.
// Assumes: WORD_W >= FRM_BITS, and tick_en gates every state change.
module sdd_word_stage
    import sdd_pkg::*;
#(
    parameter int WORD_W   = 20,
    parameter int FRM_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                wr_signed,
    input  logic [1:0]          wr_mode,
    output logic [FRM_BITS-1:0] frame_cnt,
    output logic [WORD_W-1:0]   act_word,
    output sdd_mode_e           act_mode
);

    localparam logic [WORD_W-1:0]   MID_WORD   = WORD_W'(1) << (WORD_W - 1);
    localparam logic [FRM_BITS-1:0] FRAME_LAST = '1;

    logic [WORD_W-1:0] pend_word;
    sdd_mode_e         pend_mode;
    logic [WORD_W-1:0] wr_offset;
    logic              frame_wrap;

    // Map the written word into offset-binary form.
    always_comb begin
        if (wr_signed) begin
            wr_offset = {~wr_data[WORD_W-1], wr_data[WORD_W-2:0]};
        end else begin
            wr_offset = wr_data;
        end
    end

    assign frame_wrap = tick_en && (frame_cnt == FRAME_LAST);

    // Capture the most recent host write as the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_word <= MID_WORD;
            pend_mode <= SDD_ORD1;
        end else if (wr_en) begin
            pend_word <= wr_offset;
            pend_mode <= sdd_mode_e'(wr_mode);
        end
    end

    // Count ticks within one modulator frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_cnt <= '0;
        end else if (tick_en) begin
            frame_cnt <= frame_cnt + 1'b1;
        end
    end

    // Promote the pending set at the frame boundary only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_word <= MID_WORD;
            act_mode <= SDD_ORD1;
        end else if (frame_wrap) begin
            act_word <= pend_word;
            act_mode <= pend_mode;
        end
    end

    AST_LOAD_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_word) || !$stable(act_mode)) |-> $past(frame_wrap)); // R3

endmodule

// File: rtl/sdd_first_order.sv
// First-order single-bit noise shaper: an offset-binary accumulator whose
// carry is the output bit.
// Assumes: word is offset binary; the accumulator never leaves [0, 2^WORD_W).
module sdd_first_order #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [WORD_W-1:0] word,
    output logic              bit_q
);

    localparam logic [WORD_W-1:0] MID_WORD = WORD_W'(1) << (WORD_W - 1);

    logic [WORD_W-1:0] acc;
    logic [WORD_W:0]   sum;

    // Add the word to the residue; the carry is the quantised bit.
    always_comb begin
        sum = {1'b0, acc} + {1'b0, word};
    end

    // Keep the residue and register the output bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= MID_WORD;
            bit_q <= 1'b0;
        end else if (tick_en) begin
            acc   <= sum[WORD_W-1:0];
            bit_q <= sum[WORD_W];
        end
    end

    AST_ORD1_NO_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick_en) && $past(!word[WORD_W-1]) && tick_en && !word[WORD_W-1] && bit_q)
        |=> !bit_q); // R2

endmodule

// File: rtl/sdd_second_order.sv
// Second-order single-bit noise shaper in error-feedback form. The quantiser
// input is word + 2*e[n-1] - e[n-2], which gives a noise transfer of
// (1 - z^-1)^2. Both error states saturate instead of wrapping.
// Assumes: word is offset binary; the quantiser threshold is half scale.
module sdd_second_order #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [WORD_W-1:0] word,
    output logic              bit_q
);

    localparam int SW = WORD_W + 5;
    localparam logic signed [SW-1:0] FULL = SW'(2 ** WORD_W);
    localparam logic signed [SW-1:0] HALF = SW'(2 ** (WORD_W - 1));
    localparam logic signed [SW-1:0] EMAX = SW'(2 ** (WORD_W + 1));

    logic signed [SW-1:0] e1;
    logic signed [SW-1:0] e2;
    logic signed [SW-1:0] qin;
    logic signed [SW-1:0] e_raw;
    logic signed [SW-1:0] e_sat;
    logic                 y;

    // Form the quantiser input, decide the bit and clamp the new error.
    always_comb begin
        qin   = $signed({{(SW - WORD_W){1'b0}}, word}) + (e1 <<< 1) - e2;
        y     = (qin >= HALF);
        e_raw = y ? (qin - FULL) : qin;
        if (e_raw > EMAX) begin
            e_sat = EMAX;
        end else if (e_raw < -EMAX) begin
            e_sat = -EMAX;
        end else begin
            e_sat = e_raw;
        end
    end

    // Shift the error history and register the output bit on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e1    <= '0;
            e2    <= '0;
            bit_q <= 1'b0;
        end else if (tick_en) begin
            e1    <= e_sat;
            e2    <= e1;
            bit_q <= y;
        end
    end

    AST_ORD2_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick_en) && ($past(word) == '0) && ($past(e1) == '0) && ($past(e2) == '0))
        |-> (!bit_q && (e1 == '0))); // R8

endmodule

// File: rtl/sdd_pwm.sv
// PWM fallback: the output is high while the frame counter is below the top
// FRM_BITS bits of the word.
// Assumes: frame_cnt advances once per tick and wraps every 2^FRM_BITS ticks.
module sdd_pwm #(
    parameter int WORD_W   = 20,
    parameter int FRM_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic [WORD_W-1:0]   word,
    input  logic [FRM_BITS-1:0] frame_cnt,
    output logic                bit_q
);

    logic [FRM_BITS-1:0] duty;

    assign duty = word[WORD_W-1 -: FRM_BITS];

    // Compare the frame position with the duty on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (tick_en) begin
            bit_q <= (frame_cnt < duty);
        end
    end

    AST_PWM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tick_en) && ($past(duty) == '0)) |-> !bit_q); // R6

endmodule

// File: rtl/sdd_ctrl_dac.sv
// Top level of the sigma-delta tuning DAC. It ties the word stage to the three
// modulators and registers the selected bit onto the output pin.
// Assumes: PWM_BITS <= WORD_W; all modulators run continuously on each tick.
module sdd_ctrl_dac
    import sdd_pkg::*;
#(
    parameter int WORD_W   = 20,
    parameter int PWM_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_signed,
    input  logic [1:0]        wr_mode,
    output logic              dac_out
);

    logic [PWM_BITS-1:0] frame_cnt;
    logic [WORD_W-1:0]   act_word;
    sdd_mode_e           act_mode;
    logic                ord1_bit;
    logic                ord2_bit;
    logic                pwm_bit;

    sdd_word_stage #(.WORD_W(WORD_W), .FRM_BITS(PWM_BITS)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_signed (wr_signed),
        .wr_mode   (wr_mode),
        .frame_cnt (frame_cnt),
        .act_word  (act_word),
        .act_mode  (act_mode)
    );

    sdd_first_order #(.WORD_W(WORD_W)) u_ord1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .word    (act_word),
        .bit_q   (ord1_bit)
    );

    sdd_second_order #(.WORD_W(WORD_W)) u_ord2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .word    (act_word),
        .bit_q   (ord2_bit)
    );

    sdd_pwm #(.WORD_W(WORD_W), .FRM_BITS(PWM_BITS)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .word      (act_word),
        .frame_cnt (frame_cnt),
        .bit_q     (pwm_bit)
    );

    // Route the bit of the active mode to the pin register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_out <= 1'b0;
        end else if (tick_en) begin
            case (act_mode)
                SDD_ORD2: dac_out <= ord2_bit;
                SDD_PWM:  dac_out <= pwm_bit;
                default:  dac_out <= ord1_bit;
            endcase
        end
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(dac_out)); // R7

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !dac_out); // R1

endmodule

// File: tb/sdd_ctrl_dac_tb.sv
module sdd_ctrl_dac_tb;

    localparam int W  = 8;
    localparam int N  = 6;
    localparam int F  = 1 << W;
    localparam int FR = 1 << N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         wr_signed = 1'b0;
    logic [1:0]   wr_mode = 2'b00;
    logic         dac_out;

    int checks = 0;
    int errors = 0;
    int tick_sel = 0;
    int tick_ph = 0;
    bit done = 1'b0;

    sdd_ctrl_dac #(.WORD_W(W), .PWM_BITS(N)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_signed (wr_signed),
        .wr_mode   (wr_mode),
        .dac_out   (dac_out)
    );

    always #4 clk = ~clk;

    // Tick pattern: 0 = every clock, 1 = never, 2 = every fourth clock.
    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % 4;
        case (tick_sel)
            0:       tick_en = 1'b1;
            1:       tick_en = 1'b0;
            default: tick_en = (tick_ph == 0);
        endcase
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input int code, input bit sg, input int md);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_data   = code[W-1:0];
        wr_signed = sg;
        wr_mode   = md[1:0];
        @(negedge clk);
        wr_en = 1'b0;
        repeat (FR + 4) @(negedge clk);
    endtask

    task automatic count(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            c += int'(dac_out);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        int held;
        int exp;
        repeat (5) @(negedge clk);
        check(dac_out == 1'b0, "R1 output low in reset", int'(dac_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        count(F, c);
        check(c == F / 2, "R1 mid-scale density after reset", c, F / 2);

        // R2: exhaustive first-order sweep, exact count over 2^W ticks
        for (int u = 0; u < F; u++) begin
            load(u, 1'b0, 0);
            count(F, c);
            check(c == u, "R2 first-order ones", c, u);
        end

        // R9: spare mode code acts as first order
        load(37, 1'b0, 3);
        count(F, c);
        check(c == 37, "R9 spare mode code", c, 37);
        load(200, 1'b0, 3);
        count(F, c);
        check(c == 200, "R9 spare mode code", c, 200);

        // R4: signed words map to offset by adding half scale
        for (int s = -128; s < 128; s += 51) begin
            load(s, 1'b1, 0);
            count(F, c);
            check(c == s + F / 2, "R4 signed word", c, s + F / 2);
        end
        load(127, 1'b1, 0);
        count(F, c);
        check(c == 255, "R4 signed maximum", c, 255);

        // R3: two writes inside one frame, the last one wins
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'd10;  wr_signed = 1'b0; wr_mode = 2'b00;
        @(negedge clk);
        wr_data = 8'd201;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (FR + 4) @(negedge clk);
        count(F, c);
        check(c == 201, "R3 last write wins at frame start", c, 201);

        // R6: exhaustive PWM sweep over one period
        for (int u = 0; u < F; u++) begin
            load(u, 1'b0, 2);
            count(FR, c);
            exp = u >> (W - N);
            check(c == exp, "R6 PWM high ticks", c, exp);
        end

        // R5: second-order density within one LSB over 16 full-scale periods
        for (int u = F / 4; u <= 3 * F / 4; u += 16) begin
            load(u, 1'b0, 1);
            repeat (F) @(negedge clk);
            count(16 * F, c);
            exp = 16 * u;
            check((c - exp <= 16) && (exp - c <= 16), "R5 second-order density", c, exp);
        end

        // R8: bounded error states keep the bottom code within one LSB
        load(0, 1'b0, 1);
        repeat (F) @(negedge clk);
        count(16 * F, c);
        check(c <= 16, "R8 saturating states at code 0", c, 0);

        // R7: no tick, no change; then ticks every fourth clock
        load(128, 1'b0, 2);
        tick_sel = 1;
        repeat (3) @(negedge clk);
        held = int'(dac_out);
        c = 0;
        repeat (40) begin
            @(negedge clk);
            if (int'(dac_out) != held) c++;
        end
        check(c == 0, "R7 output held without tick", c, 0);
        tick_sel = 2;
        repeat (12) @(negedge clk);
        count(4 * FR, c);
        check(c == 4 * 32, "R7 PWM counted in ticks", c, 4 * 32);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule